// File: doc/BRIEF.md
# Signal-Conditioner Configuration Slave

This block holds the control settings of a multi-lane signal conditioner and presents them as per-channel control fields: a 3-bit equalizer select, a 2-bit output-swing select and a 3-bit de-emphasis select for each channel. It also presents two global active-low controls, one for loopback and one for power-down. A mode pin picks where those fields come from. With the pin high, they are taken live from the strap inputs. With the pin low, they come from a small register file. That file is loaded from the straps during reset and can then be rewritten over an I2C slave port.

The I2C port works on a system clock. SCL and SDA pass through two-flop synchronizers, and START and STOP are recognised as SDA edges while SCL is high. Three address-select pins set bits of the 7-bit slave address, so eight devices can share one bus. A write transaction sends the address, then one dummy byte that is acknowledged and dropped, then data bytes that fill indices 0, 1, 2 and so on. A read transaction has no dummy byte and starts at index 0, which returns the lane signal-detect status.

Top module: `sigcond_cfg_slave`

## Requirements
- R1: With `mode_strap_i` high, every control output equals the matching strap input and follows it combinationally. With `mode_strap_i` low, the outputs come only from the register file, and strap changes have no effect.
- R2: While `rst_n` is low, each channel byte and the control byte are loaded from the current strap inputs. Right after reset, with the mode pin low, the outputs therefore equal the straps that were present during reset.
- R3: The 7-bit slave address has bits 6 and 5 set to 1 and bits 3 and 2 set to 0. Bit 4 is `addr_sel_i[2]`, bit 1 is `addr_sel_i[1]` and bit 0 is `addr_sel_i[0]`, so with all three pins low the write address byte is 0xC0. The address byte carries the address in bits 7..1 and the direction in bit 0 (1 = read). The slave acknowledges only a matching address; on any other address it drives nothing and changes no register.
- R4: Bytes are shifted MSB first. In a write, the first byte after the address is acknowledged and discarded. The following bytes go to indices 0, 1, 2 and so on.
- R5: Channel c is stored at index 1+c as {eq[7:5], swing[4:3], deemph[2:0]}. Index 1+NUM_CH is the control byte: bit 1 is loopback_n and bit 0 is power-down_n. A write to index 0 is acknowledged but has no effect.
- R6: The register file has 12 indices (0..11). A data byte aimed at index 12 or higher is not acknowledged and changes nothing.
- R7: In a read, index 0 returns `sig_det_i` (bit n = lane n). Indices 1..11 return the stored bytes, and indices past 11 return 0x00.
- R8: Every START, including a repeated START, and every STOP returns the byte index to 0.
- R9: A data byte reaches the register file only after its acknowledge clock completes. A byte cut short by a STOP leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads registers from straps |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_sel_i | input | 3 | Address pins for address bits {4,1,0} |
| mode_strap_i | input | 1 | 1 = outputs from straps, 0 = outputs from registers |
| strap_eq_i | input | NUM_CH*3 | Strap equalizer selects, channel 0 in the low bits |
| strap_swing_i | input | NUM_CH*2 | Strap output-swing selects |
| strap_deemph_i | input | NUM_CH*3 | Strap de-emphasis selects |
| strap_loop_n_i | input | 1 | Strap loopback control, active low |
| strap_pwrdn_n_i | input | 1 | Strap power-down control, active low |
| sig_det_i | input | 8 | Lane signal-detect status, bit n = lane n |
| eq_o | output | NUM_CH*3 | Effective equalizer selects |
| swing_o | output | NUM_CH*2 | Effective output-swing selects |
| deemph_o | output | NUM_CH*3 | Effective de-emphasis selects |
| loop_n_o | output | 1 | Effective loopback control, active low |
| pwrdn_n_o | output | 1 | Effective power-down control, active low |

## Verification
The bench writes a dummy byte that differs from every real payload byte. A design that kept the dummy would land every payload one index late, and the channel fields would come out wrong. It also writes one byte past the last index and expects a NACK with no change, and it reads past the end expecting zeros, which catches pointers that wrap or run off the end. Separate tests cut a byte short with a STOP, follow a write with a repeated START into a read, and address the wrong device. A design that committed bits as they arrived, kept the index across transactions, or answered a foreign address would change outputs or return something other than the status byte. Strap mode and reset preload are checked by changing the straps after reset and watching whether the outputs follow in each mode.

// File: rtl/sigcond_cfg_pkg.sv
// Shared constants, state encoding and address helper for the
// signal-conditioner configuration slave.
package sigcond_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int EQ_W   = 3;
    localparam int SW_W   = 2;
    localparam int DE_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
    } slv_state_t;

    // Merge the three address pins into bits 4, 1 and 0 of the base address.
    function automatic logic [6:0] merge_addr(input logic [6:0] base,
                                              input logic [2:0] pins);
        logic [6:0] a;
        a    = base;
        a[4] = pins[2];
        a[1] = pins[1];
        a[0] = pins[0];
        return a;
    endfunction
endpackage

// File: rtl/sigcond_cfg_sync.sv
// Synchronizes SCL/SDA into the system clock domain and reports SCL edges
// and START/STOP conditions. Assumes the bus is slow relative to clk.
module sigcond_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~scl_d;
    assign scl_fall_o = ~scl_s & scl_d;
    assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sigcond_cfg_engine.sv
// I2C slave protocol engine: address match, dummy-byte drop on writes,
// auto-incrementing byte index, read data shifting. Writes are issued as a
// one-cycle strobe at the end of the acknowledge clock.
module sigcond_cfg_engine
    import sigcond_cfg_pkg::*;
#(
    parameter int NUM_BYTES = 12,
    localparam int PTR_W    = $clog2(NUM_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [6:0]         dev_addr,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [PTR_W-1:0]   wr_idx,
    output logic [BYTE_W-1:0]  wr_data,
    output logic [PTR_W-1:0]   rd_idx,
    input  logic [BYTE_W-1:0]  rd_data
);
    slv_state_t        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, txreg;
    logic [PTR_W-1:0]  ptr, ptr_next;
    logic              rw, dummy, accept, mnack;

    assign ptr_next = (ptr == PTR_W'(NUM_BYTES)) ? ptr : ptr + PTR_W'(1);
    assign rd_idx   = (state == ST_RD_ACK) ? ptr_next : ptr;

    // Protocol state machine, driven by synchronized SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  txreg <= '0;
            ptr <= '0;  rw <= 1'b0;  dummy <= 1'b0;  accept <= 1'b0;
            mnack <= 1'b0;  sda_oe <= 1'b0;
            wr_en <= 1'b0;  wr_idx <= '0;  wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state <= ST_ADDR;  bitcnt <= '0;  ptr <= '0;
                dummy <= 1'b1;  sda_oe <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE;  ptr <= '0;  sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (shreg[7:1] == dev_addr) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_WR: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            accept <= dummy || (ptr < PTR_W'(NUM_BYTES));
                            sda_oe <= dummy || (ptr < PTR_W'(NUM_BYTES));
                            state  <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        if (!accept) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_WR;
                            if (dummy) begin
                                dummy <= 1'b0;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_idx  <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + PTR_W'(1);
                            end
                        end
                    end
                    ST_RD: if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mnack <= sda_s;
                        end else if (scl_fall) begin
                            if (mnack) begin
                                state <= ST_IDLE;
                            end else begin
                                bitcnt <= '0;
                                ptr    <= ptr_next;
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: the write strobe never targets an index past the file.
    a_r6_no_write_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < PTR_W'(NUM_BYTES)));
    // R4: writes only happen in a write-direction transaction.
    a_r4_write_only_when_writing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rw);
    // R8: any START returns the byte index to zero.
    a_r8_index_cleared_by_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (ptr == '0));
    // R7: the slave releases SDA during the master's acknowledge bit.
    a_r7_release_for_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_oe);
endmodule

// File: rtl/sigcond_cfg_regfile.sv
// Configuration byte storage with strap preload on reset, a read port that
// places lane status at index 0, and the strap/register output select.
module sigcond_cfg_regfile
    import sigcond_cfg_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int NUM_BYTES = 12,
    localparam int PTR_W    = $clog2(NUM_BYTES + 1),
    localparam int CTRL_IDX = 1 + NUM_CH,
    localparam int SW_LSB   = DE_W,
    localparam int EQ_LSB   = DE_W + SW_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_strap,
    input  logic [NUM_CH*EQ_W-1:0] strap_eq,
    input  logic [NUM_CH*SW_W-1:0] strap_sw,
    input  logic [NUM_CH*DE_W-1:0] strap_de,
    input  logic                   strap_loop_n,
    input  logic                   strap_pwrdn_n,
    input  logic [BYTE_W-1:0]      sig_det,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [PTR_W-1:0]       rd_idx,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NUM_CH*EQ_W-1:0] eq_o,
    output logic [NUM_CH*SW_W-1:0] sw_o,
    output logic [NUM_CH*DE_W-1:0] de_o,
    output logic                   loop_n_o,
    output logic                   pwrdn_n_o
);
    logic [BYTE_W-1:0]           regs    [NUM_BYTES];
    logic [BYTE_W-1:0]           preload [NUM_BYTES];
    logic [NUM_BYTES*BYTE_W-1:0] reg_flat;

    // Build the reset image from the straps.
    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) preload[i] = '0;
        for (int c = 0; c < NUM_CH; c++)
            preload[1+c] = {strap_eq[c*EQ_W +: EQ_W], strap_sw[c*SW_W +: SW_W],
                            strap_de[c*DE_W +: DE_W]};
        preload[CTRL_IDX] = {{(BYTE_W-2){1'b0}}, strap_loop_n, strap_pwrdn_n};
    end

    // Storage: preload on reset, byte writes afterwards (index 0 read-only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BYTES; i++) regs[i] <= preload[i];
        end else begin
            for (int i = 1; i < NUM_BYTES; i++)
                if (wr_en && wr_idx == PTR_W'(i)) regs[i] <= wr_data;
        end
    end

    // Read port: status at index 0, zero past the end.
    always_comb begin
        rd_data = (rd_idx == '0) ? sig_det : '0;
        for (int i = 1; i < NUM_BYTES; i++)
            if (rd_idx == PTR_W'(i)) rd_data = regs[i];
    end

    // Flattened storage view for the checks below.
    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) reg_flat[i*BYTE_W +: BYTE_W] = regs[i];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign eq_o[c*EQ_W +: EQ_W] = mode_strap ? strap_eq[c*EQ_W +: EQ_W]
                                                 : regs[1+c][EQ_LSB +: EQ_W];
        assign sw_o[c*SW_W +: SW_W] = mode_strap ? strap_sw[c*SW_W +: SW_W]
                                                 : regs[1+c][SW_LSB +: SW_W];
        assign de_o[c*DE_W +: DE_W] = mode_strap ? strap_de[c*DE_W +: DE_W]
                                                 : regs[1+c][0 +: DE_W];
    end
    assign loop_n_o  = mode_strap ? strap_loop_n  : regs[CTRL_IDX][1];
    assign pwrdn_n_o = mode_strap ? strap_pwrdn_n : regs[CTRL_IDX][0];

    // R9: storage changes only through a completed write strobe.
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat));
    // R5: a write to index 0 leaves every stored byte alone.
    a_r5_index0_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> $stable(reg_flat));
endmodule

// File: rtl/sigcond_cfg_slave.sv
// Top level: synchronizer, protocol engine and register file. Assumes SCL
// phases last several clk cycles (standard-rate bus on a fast system clock).
module sigcond_cfg_slave
    import sigcond_cfg_pkg::*;
#(
    parameter int         NUM_CH    = 2,
    parameter int         NUM_BYTES = 12,
    parameter logic [6:0] BASE_ADDR = 7'h60,
    localparam int        PTR_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [2:0]             addr_sel_i,
    input  logic                   mode_strap_i,
    input  logic [NUM_CH*EQ_W-1:0] strap_eq_i,
    input  logic [NUM_CH*SW_W-1:0] strap_swing_i,
    input  logic [NUM_CH*DE_W-1:0] strap_deemph_i,
    input  logic                   strap_loop_n_i,
    input  logic                   strap_pwrdn_n_i,
    input  logic [BYTE_W-1:0]      sig_det_i,
    output logic [NUM_CH*EQ_W-1:0] eq_o,
    output logic [NUM_CH*SW_W-1:0] swing_o,
    output logic [NUM_CH*DE_W-1:0] deemph_o,
    output logic                   loop_n_o,
    output logic                   pwrdn_n_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx, rd_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic [6:0]        dev_addr;

    assign dev_addr = merge_addr(BASE_ADDR, addr_sel_i);

    sigcond_cfg_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    sigcond_cfg_engine #(.NUM_BYTES(NUM_BYTES)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .sda_oe(sda_oe_o), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    sigcond_cfg_regfile #(.NUM_CH(NUM_CH), .NUM_BYTES(NUM_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap_i),
        .strap_eq(strap_eq_i), .strap_sw(strap_swing_i), .strap_de(strap_deemph_i),
        .strap_loop_n(strap_loop_n_i), .strap_pwrdn_n(strap_pwrdn_n_i),
        .sig_det(sig_det_i), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .eq_o(eq_o), .sw_o(swing_o),
        .de_o(deemph_o), .loop_n_o(loop_n_o), .pwrdn_n_o(pwrdn_n_o)
    );
endmodule

// File: tb/test_sigcond_cfg_slave.sv
// Bench: bit-banged I2C master, table-driven write vectors, then directed
// tests for reset, strap mode, addressing, bounds and aborted bytes.
module test_sigcond_cfg_slave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda_drv = 1'b1;
    logic       sda_line, sda_oe;
    logic [2:0] addr_sel = 3'b000;
    logic       mode = 1'b0;
    logic [5:0] s_eq = 6'b101_011;
    logic [3:0] s_sw = 4'b10_01;
    logic [5:0] s_de = 6'b110_001;
    logic       s_lb = 1'b1, s_pd = 1'b0;
    logic [7:0] sig_det = 8'h08;
    logic [5:0] eq;
    logic [3:0] sw;
    logic [5:0] de;
    logic       lb, pd;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    assign sda_line = sda_drv & ~sda_oe;
    always #10 clk = ~clk;

    sigcond_cfg_slave i_sigcond_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .addr_sel_i(addr_sel), .mode_strap_i(mode), .strap_eq_i(s_eq),
        .strap_swing_i(s_sw), .strap_deemph_i(s_de), .strap_loop_n_i(s_lb),
        .strap_pwrdn_n_i(s_pd), .sig_det_i(sig_det), .eq_o(eq), .swing_o(sw),
        .deemph_o(de), .loop_n_o(lb), .pwrdn_n_o(pd)
    );

    // Vectors: {addr pins, channel-0 byte, channel-1 byte, control byte}.
    localparam logic [26:0] VEC [6] = '{
        {3'b000, 8'hA5, 8'h3C, 8'h02}, {3'b001, 8'hFF, 8'h00, 8'h01},
        {3'b010, 8'h12, 8'hED, 8'h03}, {3'b100, 8'h81, 8'h7E, 8'h00},
        {3'b111, 8'h5A, 8'hC3, 8'h02}, {3'b011, 8'h00, 8'hFF, 8'h03}};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] abyte(input logic [2:0] p, input logic rd);
        return {2'b11, p[2], 2'b00, p[1], p[0], rd};
    endfunction

    // Expected outputs from a channel-0 byte, channel-1 byte and control byte.
    task automatic check_outs(input string req, input logic [7:0] c0, input logic [7:0] c1,
                              input logic [7:0] ct);
        check(req, {26'd0, eq}, {26'd0, c1[7:5], c0[7:5]});
        check(req, {28'd0, sw}, {28'd0, c1[4:3], c0[4:3]});
        check(req, {26'd0, de}, {26'd0, c1[2:0], c0[2:0]});
        check(req, {30'd0, lb, pd}, {30'd0, ct[1:0]});
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(Q/2); sda_drv = 1'b0; tick(Q/2); scl = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            tick(Q/2); sda_drv = b[7-i]; tick(Q/2);
            scl = 1'b1; tick(Q); scl = 1'b0;
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        tick(Q/2); sda_drv = 1'b1; tick(Q/2);
        scl = 1'b1; tick(Q/2); ack = !sda_line; tick(Q/2); scl = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b, input bit give_ack);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q/2); sda_drv = 1'b1; tick(Q/2);
            scl = 1'b1; tick(Q/2); b = {b[6:0], sda_line}; tick(Q/2); scl = 1'b0;
        end
        tick(Q/2); sda_drv = give_ack ? 1'b0 : 1'b1; tick(Q/2);
        scl = 1'b1; tick(Q); scl = 1'b0;
    endtask

    // Address plus n bytes from wbuf; counts NACKs; optional STOP.
    task automatic burst_write(input logic [7:0] ab, input int n, input bit do_stop,
                               output int nacks);
        bit ack;
        nacks = 0;
        i2c_start();
        write_byte(ab, ack); if (!ack) nacks++;
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i], ack); if (!ack) nacks++;
        end
        if (do_stop) i2c_stop();
    endtask

    task automatic burst_read(input logic [7:0] ab, input int n, output int nacks);
        bit ack;
        nacks = 0;
        i2c_start();
        write_byte(ab, ack); if (!ack) nacks++;
        for (int i = 0; i < n; i++) read_byte(rbuf[i], i != n - 1);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int nk;
        tick(5); rst_n = 1'b1; tick(4);
        // R2: preload from straps present during reset.
        check_outs("R2 preload", {s_eq[2:0], s_sw[1:0], s_de[2:0]},
                   {s_eq[5:3], s_sw[3:2], s_de[5:3]}, {6'd0, s_lb, s_pd});
        // R1: register mode ignores strap changes.
        s_eq = 6'b000_111; s_sw = 4'b01_10; s_de = 6'b011_100; s_lb = 1'b0; s_pd = 1'b1;
        tick(2);
        check_outs("R1 register mode ignores straps", 8'b011_01_001, 8'b101_10_110, 8'h02);
        // R1: strap mode follows pins live.
        mode = 1'b1; tick(1);
        check_outs("R1 strap mode", 8'b111_10_100, 8'b000_01_011, 8'h01);
        s_eq = 6'b010_001; s_lb = 1'b1; tick(1);
        check_outs("R1 strap mode live", 8'b001_10_100, 8'b010_01_011, 8'h03);
        mode = 1'b0; tick(2);

        // R3/R4/R5: vector walk, dummy 0xEE and index-0 0x77 must not land.
        for (int v = 0; v < 6; v++) begin
            addr_sel = VEC[v][26:24];
            wbuf[0] = 8'hEE; wbuf[1] = 8'h77;
            wbuf[2] = VEC[v][23:16]; wbuf[3] = VEC[v][15:8]; wbuf[4] = VEC[v][7:0];
            burst_write(abyte(addr_sel, 1'b0), 5, 1'b1, nk);
            check("R3 ack on matching address", nk, 0);
            check_outs("R4 R5 vector", VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
        end
        addr_sel = 3'b000;
        check("R3 address byte with pins low", {24'd0, abyte(3'b000, 1'b0)}, 32'hC0);

        // R3: foreign address is not acknowledged and changes nothing.
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'hFF; wbuf[3] = 8'hFF; wbuf[4] = 8'h00;
        burst_write(abyte(3'b001, 1'b0), 5, 1'b1, nk);
        check("R3 foreign address nacked", nk, 6);
        check_outs("R3 foreign address no effect", 8'h00, 8'hFF, 8'h03);

        // R6: full 12-byte burst then one extra byte nacked.
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'hAA; wbuf[3] = 8'h55; wbuf[4] = 8'h03;
        for (int i = 4; i < 12; i++) wbuf[i+1] = 8'h40 + 8'(i);
        wbuf[13] = 8'h99;
        burst_write(abyte(3'b000, 1'b0), 14, 1'b1, nk);
        check("R6 only byte past end nacked", nk, 1);
        check_outs("R6 outputs after overrun", 8'hAA, 8'h55, 8'h03);

        // R7: read status, contents, zeros past end.
        burst_read(abyte(3'b000, 1'b1), 14, nk);
        check("R7 read address acked", nk, 0);
        check("R7 status byte", {24'd0, rbuf[0]}, 32'h08);
        check("R7 byte1", {24'd0, rbuf[1]}, 32'hAA);
        check("R7 byte2", {24'd0, rbuf[2]}, 32'h55);
        check("R7 byte3", {24'd0, rbuf[3]}, 32'h03);
        for (int i = 4; i < 12; i++)
            check("R7 storage byte", {24'd0, rbuf[i]}, {24'd0, 8'h40 + 8'(i)});
        check("R7 past end idx12", {24'd0, rbuf[12]}, 32'h00);
        check("R7 past end idx13", {24'd0, rbuf[13]}, 32'h00);

        // R8: STOP restarts the index at 0.
        wbuf[0] = 8'hEE; wbuf[1] = 8'h00; wbuf[2] = 8'h11;
        burst_write(abyte(3'b000, 1'b0), 3, 1'b1, nk);
        wbuf[2] = 8'h22;
        burst_write(abyte(3'b000, 1'b0), 3, 1'b1, nk);
        check_outs("R8 index restart after stop", 8'h22, 8'h55, 8'h03);
        // R8: repeated START into a read begins at the status byte.
        sig_det = 8'h81;
        wbuf[2] = 8'h33;
        burst_write(abyte(3'b000, 1'b0), 3, 1'b0, nk);
        burst_read(abyte(3'b000, 1'b1), 2, nk);
        check("R8 repeated start reads status", {24'd0, rbuf[0]}, 32'h81);
        check("R8 then byte1", {24'd0, rbuf[1]}, 32'h33);

        // R9: byte cut short by STOP does not reach outputs.
        begin
            bit ack;
            i2c_start();
            write_byte(abyte(3'b000, 1'b0), ack);
            write_byte(8'hEE, ack);
            write_byte(8'h00, ack);
            send_bits(8'hC7, 4);
            i2c_stop();
        end
        tick(4);
        check_outs("R9 partial byte ignored", 8'h33, 8'h55, 8'h03);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule